// File: doc/BRIEF.md
# Partitioned Two-Cycle Integer Execution Unit

This block is a 32-bit execution unit built from six independent functional lanes: add/subtract, step (increment/decrement), shift/rotate, bitwise logic, 16x16 multiply and bit-merge. Every lane has its own bank of operand flip-flops. An accepted instruction loads only the bank of the lane that its opcode names. The other lanes keep their old operands, so their logic does not toggle and burns no dynamic power.

On the clock after capture, a result selector picks the active lane's output. The zero flag is derived from that selected value in the same cycle. Result, flags and write-enable are then registered. A four-bit condition code, evaluated against the incoming carry and zero flags, can block the write. A blocked instruction still produces a valid strobe, with write-enable low and the incoming flags passed back unchanged.

The issue side is a valid/ready port. The unit takes one instruction every two clocks: `in_ready` drops for exactly one cycle after each acceptance. While `in_ready` is low, any values on the issue inputs are ignored and the upstream must hold its instruction. The completion side is a plain one-cycle strobe with no back-pressure. The consumer must take the result in the cycle `out_valid` is high.

Top module: `gated_alu`

## Requirements
- R1: Opcode bits [4:2] name the lane: 0 add, 1 step, 2 shift/rotate, 3 logic, 4 multiply, 5 bit-merge. Bits [1:0] pick the variant. Lane codes 6 and 7 complete with out_we=0, out_result=0, and out_c/out_z equal to the flags given at issue.
- R2: Only the named lane's operand registers load on acceptance. Every result depends only on its own instruction's operands, even when consecutive instructions use different lanes.
- R3: An instruction is accepted when in_valid and in_ready are both high. in_ready is low in the cycle after acceptance and high otherwise (high after reset). out_valid is high for exactly one cycle, two cycles after the accepting edge. Issue inputs presented while in_ready is low have no effect.
- R4: In the add lane, variant 0 gives D+S and variant 1 gives D-S. Variant 2 gives D+S+Cin and variant 3 gives D-S-Cin, where Cin is in_flag_c. C is the carry out for the additions and the borrow for the subtractions.
- R5: In the step lane, bit 0 of the variant selects decrement and bit 1 selects a step of 4 instead of 1. C is the carry out on increment or the borrow on decrement.
- R6: In the shift/rotate lane, the amount is S[4:0] and the variants are 0 rotate-left, 1 rotate-right, 2 shift-left and 3 logical shift-right. C is the last bit moved out, and C is 0 when the amount is 0.
- R7: In the logic lane, the variants are 0 AND, 1 OR, 2 XOR and 3 D AND NOT S. The multiply lane returns D[15:0]*S[15:0] unsigned for every variant. Both lanes return C=0.
- R8: The bit-merge lane returns (D AND NOT S) OR (S AND a fill bit). The fill bit is C, NOT C, Z or NOT Z of the issue flags for variants 0 to 3. The lane returns C=0.
- R9: On a written result, out_z is 1 exactly when all 32 result bits are 0.
- R10: The condition code passes when in_cond[{in_flag_c,in_flag_z}] is 1, so 1111 always passes and 0000 never does. When it fails: out_we=0, out_result=0, and out_c/out_z equal the issue flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can accept an instruction |
| in_opcode | input | 5 | Lane select [4:2] and variant [1:0] |
| in_d | input | 32 | First operand (D) |
| in_s | input | 32 | Second operand (S) |
| in_flag_c | input | 1 | Current carry flag |
| in_flag_z | input | 1 | Current zero flag |
| in_cond | input | 4 | Condition truth table over {C,Z} |
| out_valid | output | 1 | Completion strobe |
| out_result | output | 32 | Result value |
| out_we | output | 1 | Destination and flag write enable |
| out_z | output | 1 | Zero flag to commit |
| out_c | output | 1 | Carry flag to commit |

## Verification
The in-RTL properties watch the handshake timing on every cycle: the one-cycle ready drop, the completion two edges after acceptance, and the single-cycle strobe. They also check that an idle lane's operand bank never changes, that a written result's zero flag matches its value, and that a blocked completion carries a zero result. What each lane computes, the carry semantics at the edges (all-ones plus one, zero minus one, shift by 0 and 31), the condition-code truth table, and the rejection of the two unused lane codes can only be shown by the bench's scenarios against its behavioural model. The same holds for interleaved lanes not disturbing each other, and for held issue inputs being ignored while busy.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int NUM_LANES = 6;
  localparam int CTLW      = 2;
  localparam int SELW      = 3;

  typedef enum logic [SELW-1:0] {
    LANE_ADD   = 3'd0,
    LANE_STEP  = 3'd1,
    LANE_SHIFT = 3'd2,
    LANE_LOGIC = 3'd3,
    LANE_MUL   = 3'd4,
    LANE_MERGE = 3'd5
  } lane_e;
endpackage

// File: rtl/alu_predecode.sv
module alu_predecode
  import alu_pkg::*;
(
  input  logic [1:0] variant,
  input  logic       flag_c,
  input  logic       flag_z,
  output logic [NUM_LANES-1:0][CTLW-1:0] ctl
);
  logic add_sub, add_cin, fill_bit;

  // Adder controls are resolved here, ahead of the operand flops.
  always_comb begin
    add_sub = variant[0];
    if (variant[1]) add_cin = variant[0] ? ~flag_c : flag_c;
    else            add_cin = variant[0];
    case (variant)
      2'd0:    fill_bit = flag_c;
      2'd1:    fill_bit = ~flag_c;
      2'd2:    fill_bit = flag_z;
      default: fill_bit = ~flag_z;
    endcase
  end

  always_comb begin
    ctl                   = '0;
    ctl[int'(LANE_ADD)]   = {add_sub, add_cin};
    ctl[int'(LANE_STEP)]  = variant;
    ctl[int'(LANE_SHIFT)] = variant;
    ctl[int'(LANE_LOGIC)] = variant;
    ctl[int'(LANE_MUL)]   = 2'b00;
    ctl[int'(LANE_MERGE)] = {1'b0, fill_bit};
  end
endmodule

// File: rtl/alu_lane.sv
module alu_lane
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int LANE  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d_in,
  input  logic [WIDTH-1:0] s_in,
  input  logic [CTLW-1:0]  ctl_in,
  output logic [WIDTH-1:0] res,
  output logic             carry
);
  localparam int SHW = $clog2(WIDTH);
  localparam int MW  = WIDTH / 2;

  logic [WIDTH-1:0] d_q, s_q;
  logic [CTLW-1:0]  ctl_q;

  // Operand partition: captures only when this lane is named.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q   <= '0;
      s_q   <= '0;
      ctl_q <= '0;
    end else if (load) begin
      d_q   <= d_in;
      s_q   <= s_in;
      ctl_q <= ctl_in;
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(d_q) && $stable(s_q) && $stable(ctl_q)));

  generate
    if (LANE == int'(LANE_ADD)) begin : g_add
      logic [WIDTH:0] sum;
      assign sum   = {1'b0, d_q} + {1'b0, s_q ^ {WIDTH{ctl_q[1]}}} + {{WIDTH{1'b0}}, ctl_q[0]};
      assign res   = sum[WIDTH-1:0];
      assign carry = sum[WIDTH] ^ ctl_q[1];
    end else if (LANE == int'(LANE_STEP)) begin : g_step
      logic [WIDTH:0] stepv, wide;
      logic unused_s;
      assign stepv = ctl_q[1] ? (WIDTH+1)'(4) : (WIDTH+1)'(1);
      assign wide  = ctl_q[0] ? ({1'b0, d_q} - stepv) : ({1'b0, d_q} + stepv);
      assign res   = wide[WIDTH-1:0];
      assign carry = wide[WIDTH];
      assign unused_s = ^s_q;
    end else if (LANE == int'(LANE_SHIFT)) begin : g_shift
      logic [SHW-1:0]     amt;
      logic [2*WIDTH-1:0] rl, rr, sl, sr;
      logic unused_s;
      assign amt = s_q[SHW-1:0];
      assign rl  = {d_q, d_q} << amt;
      assign rr  = {d_q, d_q} >> amt;
      assign sl  = {{WIDTH{1'b0}}, d_q} << amt;
      assign sr  = {d_q, {WIDTH{1'b0}}} >> amt;
      assign unused_s = ^{s_q[WIDTH-1:SHW], rl[WIDTH-1:0], rr[2*WIDTH-1:WIDTH],
                          sl[2*WIDTH-1:WIDTH+1], sr[WIDTH-2:0]};
      always_comb begin
        case (ctl_q)
          2'd0: begin res = rl[2*WIDTH-1:WIDTH]; carry = rl[WIDTH]; end
          2'd1: begin res = rr[WIDTH-1:0];       carry = rr[WIDTH-1]; end
          2'd2: begin res = sl[WIDTH-1:0];       carry = sl[WIDTH]; end
          default: begin res = sr[2*WIDTH-1:WIDTH]; carry = sr[WIDTH-1]; end
        endcase
        if (amt == '0) carry = 1'b0;
      end
    end else if (LANE == int'(LANE_LOGIC)) begin : g_logic
      always_comb begin
        case (ctl_q)
          2'd0:    res = d_q & s_q;
          2'd1:    res = d_q | s_q;
          2'd2:    res = d_q ^ s_q;
          default: res = d_q & ~s_q;
        endcase
      end
      assign carry = 1'b0;
    end else if (LANE == int'(LANE_MUL)) begin : g_mul
      logic [WIDTH-1:0] a_ext, b_ext;
      logic unused_hi;
      assign a_ext = {{(WIDTH-MW){1'b0}}, d_q[MW-1:0]};
      assign b_ext = {{(WIDTH-MW){1'b0}}, s_q[MW-1:0]};
      assign res   = a_ext * b_ext;
      assign carry = 1'b0;
      assign unused_hi = ^{d_q[WIDTH-1:MW], s_q[WIDTH-1:MW], ctl_q};
    end else begin : g_merge
      logic unused_ctl;
      assign res   = (d_q & ~s_q) | (s_q & {WIDTH{ctl_q[0]}});
      assign carry = 1'b0;
      assign unused_ctl = ctl_q[1];
    end
  endgenerate
endmodule

// File: rtl/alu_result_select.sv
module alu_result_select
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [NUM_LANES-1:0]            sel,
  input  logic [NUM_LANES-1:0][WIDTH-1:0] lane_res,
  input  logic [NUM_LANES-1:0]            lane_carry,
  output logic [WIDTH-1:0]                res,
  output logic                            carry,
  output logic                            zero
);
  // Highest index is evaluated first, so the adder (index 0) is the
  // final, shortest stage of the chain.
  always_comb begin
    res   = '0;
    carry = 1'b0;
    for (int i = NUM_LANES - 1; i >= 0; i--) begin
      if (sel[i]) begin
        res   = lane_res[i];
        carry = lane_carry[i];
      end
    end
    zero = (res == '0);
  end
endmodule

// File: rtl/gated_alu.sv
module gated_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [4:0]       in_opcode,
  input  logic [WIDTH-1:0] in_d,
  input  logic [WIDTH-1:0] in_s,
  input  logic             in_flag_c,
  input  logic             in_flag_z,
  input  logic [3:0]       in_cond,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_result,
  output logic             out_we,
  output logic             out_z,
  output logic             out_c
);
  logic busy, accept, lane_ok, cond_pass;
  logic [SELW-1:0] lane_code;
  logic [NUM_LANES-1:0] load_vec;
  logic [NUM_LANES-1:0][CTLW-1:0]  ctl_all;
  logic [NUM_LANES-1:0][WIDTH-1:0] res_all;
  logic [NUM_LANES-1:0]            cry_all;

  assign in_ready  = ~busy;
  assign accept    = in_valid & ~busy;
  assign lane_code = in_opcode[4:2];
  assign lane_ok   = (int'(lane_code) < NUM_LANES);
  assign cond_pass = in_cond[{in_flag_c, in_flag_z}];

  always_comb begin
    load_vec = '0;
    for (int i = 0; i < NUM_LANES; i++)
      load_vec[i] = accept && (int'(lane_code) == i);
  end

  alu_predecode u_pre (
    .variant (in_opcode[1:0]),
    .flag_c  (in_flag_c),
    .flag_z  (in_flag_z),
    .ctl     (ctl_all)
  );

  generate
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      alu_lane #(.WIDTH(WIDTH), .LANE(g)) u_lane (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_vec[g]),
        .d_in   (in_d),
        .s_in   (in_s),
        .ctl_in (ctl_all[g]),
        .res    (res_all[g]),
        .carry  (cry_all[g])
      );
    end
  endgenerate

  // Stage 1: issue bookkeeping that travels with the captured operands.
  logic                 st1_valid, st1_write, st1_fc, st1_fz;
  logic [NUM_LANES-1:0] st1_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      st1_valid <= 1'b0;
      st1_write <= 1'b0;
      st1_fc    <= 1'b0;
      st1_fz    <= 1'b0;
      st1_sel   <= '0;
    end else begin
      busy      <= accept;
      st1_valid <= accept;
      if (accept) begin
        st1_write <= cond_pass && lane_ok;
        st1_fc    <= in_flag_c;
        st1_fz    <= in_flag_z;
        st1_sel   <= load_vec;
      end
    end
  end

  logic [WIDTH-1:0] sel_res;
  logic             sel_c, sel_z;

  alu_result_select #(.WIDTH(WIDTH)) u_sel (
    .sel        (st1_sel),
    .lane_res   (res_all),
    .lane_carry (cry_all),
    .res        (sel_res),
    .carry      (sel_c),
    .zero       (sel_z)
  );

  // Stage 2: commit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_we     <= 1'b0;
      out_z      <= 1'b0;
      out_c      <= 1'b0;
    end else begin
      out_valid <= st1_valid;
      if (st1_valid) begin
        if (st1_write) begin
          out_result <= sel_res;
          out_we     <= 1'b1;
          out_z      <= sel_z;
          out_c      <= sel_c;
        end else begin
          out_result <= '0;
          out_we     <= 1'b0;
          out_z      <= st1_fz;
          out_c      <= st1_fc;
        end
      end
    end
  end

  assert_ready_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  assert_commit_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 out_valid);
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_we) |-> (out_z == (out_result == '0)));
  assert_blocked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_we) |-> (out_result == '0));
endmodule

// File: tb/gated_alu_test.sv
module gated_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_opcode = '0;
  logic [31:0] in_d = '0, in_s = '0;
  logic        in_flag_c = 1'b0, in_flag_z = 1'b0;
  logic [3:0]  in_cond = 4'hF;
  logic        out_valid, out_we, out_z, out_c;
  logic [31:0] out_result;

  always #5 clk = ~clk;

  gated_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_d(in_d), .in_s(in_s),
    .in_flag_c(in_flag_c), .in_flag_z(in_flag_z), .in_cond(in_cond),
    .out_valid(out_valid), .out_result(out_result), .out_we(out_we),
    .out_z(out_z), .out_c(out_c)
  );

  typedef struct {
    int          due;
    logic [31:0] r;
    logic        we, z, c;
    string       tag;
  } exp_t;

  exp_t  q[$];
  int    cyc = 0;
  int    last_acc = -10;
  int    n_checks = 0;
  int    n_fail = 0;
  string tag_override = "";

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Behavioural reference for one instruction.
  function automatic exp_t model(input logic [4:0] op, input logic [31:0] d, input logic [31:0] s,
                                 input logic fc, input logic fz, input logic [3:0] cond);
    exp_t e;
    longint unsigned a, b, t;
    logic [31:0] r;
    logic c, fill;
    int lane, v, n;
    lane = int'(op[4:2]);
    v    = int'(op[1:0]);
    a = longint'(d);
    b = longint'(s);
    r = '0; c = 1'b0;
    e.tag = "R1";
    case (lane)
      0: begin
        e.tag = "R4";
        case (v)
          0: begin t = a + b; r = t[31:0]; c = t[32]; end
          1: begin r = d - s; c = (a < b); end
          2: begin t = a + b + longint'(fc); r = t[31:0]; c = t[32]; end
          default: begin r = d - s - {31'b0, fc}; c = (a < b + longint'(fc)); end
        endcase
      end
      1: begin
        e.tag = "R5";
        t = (v >= 2) ? 4 : 1;
        if (v % 2 == 1) begin r = d - t[31:0]; c = (a < t); end
        else begin t = a + t; r = t[31:0]; c = t[32]; end
      end
      2: begin
        e.tag = "R6";
        n = int'(s[4:0]);
        r = d;
        for (int k = 0; k < n; k++) begin
          case (v)
            0: begin c = r[31]; r = {r[30:0], r[31]}; end
            1: begin c = r[0];  r = {r[0], r[31:1]}; end
            2: begin c = r[31]; r = {r[30:0], 1'b0}; end
            default: begin c = r[0]; r = {1'b0, r[31:1]}; end
          endcase
        end
      end
      3: begin
        e.tag = "R7";
        case (v)
          0: r = d & s;
          1: r = d | s;
          2: r = d ^ s;
          default: r = d & ~s;
        endcase
      end
      4: begin
        e.tag = "R7";
        t = longint'(d[15:0]) * longint'(s[15:0]);
        r = t[31:0];
      end
      5: begin
        e.tag = "R8";
        fill = (v == 0) ? fc : (v == 1) ? ~fc : (v == 2) ? fz : ~fz;
        for (int k = 0; k < 32; k++) r[k] = s[k] ? fill : d[k];
      end
      default: e.tag = "R1";
    endcase
    if (lane > 5 || !cond[{fc, fz}]) begin
      if (lane <= 5) e.tag = "R10";
      e.r = '0; e.we = 1'b0; e.z = fz; e.c = fc;
    end else begin
      e.r = r; e.we = 1'b1; e.z = (r == 32'd0); e.c = c;
    end
    if (tag_override != "") e.tag = tag_override;
    e.due = 0;
    return e;
  endfunction

  // Model: acceptance sampled at the edge, before registered state moves.
  always @(posedge clk) begin
    exp_t e;
    cyc = cyc + 1;
    if (rst_n && in_valid && in_ready) begin
      e = model(in_opcode, in_d, in_s, in_flag_c, in_flag_z, in_cond);
      e.due = cyc + 1;
      q.push_back(e);
      last_acc = cyc;
    end
    if (cyc > 60000) begin
      n_fail++;
      $display("FAIL R3 watchdog: actual=%0d cycles expected below 60000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    bit   ev;
    exp_t e;
    if (rst_n) begin
      check(in_ready == (last_acc != cyc), "R3", "in_ready",
            {31'b0, in_ready}, {31'b0, last_acc != cyc});
      ev = (q.size() > 0) && (q[0].due == cyc);
      check(out_valid == ev, "R3", "out_valid", {31'b0, out_valid}, {31'b0, ev});
      if (ev) begin
        e = q.pop_front();
        if (out_valid) begin
          check(out_result == e.r, e.tag, "result", out_result, e.r);
          check(out_we == e.we, e.tag, "write enable", {31'b0, out_we}, {31'b0, e.we});
          check(out_z == e.z, e.we ? "R9" : e.tag, "zero flag", {31'b0, out_z}, {31'b0, e.z});
          check(out_c == e.c, e.tag, "carry flag", {31'b0, out_c}, {31'b0, e.c});
        end
      end
    end
  end

  task automatic issue(input logic [4:0] op, input logic [31:0] d, input logic [31:0] s,
                       input logic fc, input logic fz, input logic [3:0] cond);
    logic took;
    @(negedge clk);
    in_valid = 1'b1; in_opcode = op; in_d = d; in_s = s;
    in_flag_c = fc; in_flag_z = fz; in_cond = cond;
    do begin
      @(posedge clk);
      took = in_ready;
    end while (!took);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // Reset state (R3): nothing pending, ready high.
    check(out_valid == 1'b0, "R3", "reset out_valid", {31'b0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R3", "reset in_ready", {31'b0, in_ready}, 32'd1);
    check(out_we == 1'b0, "R3", "reset out_we", {31'b0, out_we}, 32'd0);
    rst_n = 1'b1;
    idle(2);

    // R4 add lane corners.
    issue(5'b000_00, 32'hFFFF_FFFF, 32'h1, 0, 0, 4'hF);
    issue(5'b000_01, 32'h0, 32'h1, 0, 0, 4'hF);
    issue(5'b000_01, 32'h1234, 32'h1234, 0, 0, 4'hF);
    issue(5'b000_10, 32'hFFFF_FFFE, 32'h1, 1, 0, 4'hF);
    issue(5'b000_11, 32'h5, 32'h5, 1, 0, 4'hF);
    issue(5'b000_11, 32'h5, 32'h4, 1, 0, 4'hF);
    // R5 step lane.
    issue(5'b001_00, 32'hFFFF_FFFF, 32'h0, 0, 0, 4'hF);
    issue(5'b001_01, 32'h0, 32'h0, 0, 0, 4'hF);
    issue(5'b001_10, 32'hFFFF_FFFD, 32'h0, 0, 0, 4'hF);
    issue(5'b001_11, 32'h3, 32'h0, 0, 0, 4'hF);
    // R6 shift/rotate, amounts 0, 1, 31.
    issue(5'b010_00, 32'h8000_0001, 32'd0, 1, 0, 4'hF);
    issue(5'b010_00, 32'h8000_0001, 32'd1, 0, 0, 4'hF);
    issue(5'b010_01, 32'h8000_0001, 32'd31, 0, 0, 4'hF);
    issue(5'b010_10, 32'h4000_0000, 32'd2, 0, 0, 4'hF);
    issue(5'b010_11, 32'h0000_0003, 32'd2, 0, 0, 4'hF);
    // R7 logic and multiply.
    issue(5'b011_00, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1, 0, 4'hF);
    issue(5'b011_11, 32'hFFFF_00FF, 32'h00FF_00FF, 1, 0, 4'hF);
    issue(5'b100_00, 32'hABCD_FFFF, 32'h1234_FFFF, 1, 0, 4'hF);
    // R8 bit-merge with each fill source.
    for (int v = 0; v < 4; v++) issue({3'b101, 2'(v)}, 32'h1234_5678, 32'h00FF_FF00, 1, 0, 4'hF);
    // R1 unused lane codes.
    issue(5'b110_00, 32'h1, 32'h1, 1, 0, 4'hF);
    issue(5'b111_11, 32'h1, 32'h1, 0, 1, 4'hF);
    // R10 condition codes: never, and single-term truth tables.
    issue(5'b000_00, 32'h1, 32'h1, 0, 0, 4'h0);
    issue(5'b000_00, 32'h1, 32'h1, 1, 0, 4'b0100);
    issue(5'b000_00, 32'h1, 32'h1, 0, 1, 4'b0100);
    issue(5'b000_00, 32'h1, 32'h1, 1, 1, 4'b0111);
    idle(4);

    // R2: lanes interleaved back to back; each result uses only its own operands.
    tag_override = "R2";
    for (int k = 0; k < 24; k++)
      issue({3'(k % 6), 2'(k % 4)}, 32'h1000_0000 + 32'(k * 77), 32'(k * 3 + 1), 1'(k % 2), 0, 4'hF);
    tag_override = "";
    idle(3);

    // R3: valid held with changing data while busy; only accepted beats count.
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_opcode = 5'b000_00; in_d = 32'(k * 1000); in_s = 32'(k);
      in_flag_c = 0; in_flag_z = 0; in_cond = 4'hF;
    end
    idle(4);

    // Mixed random traffic.
    for (int k = 0; k < 400; k++) begin
      logic [3:0] cnd;
      cnd = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
      issue(5'($urandom), $urandom, ($urandom_range(0, 1) == 1) ? $urandom : 32'($urandom_range(0, 40)),
            1'($urandom), 1'($urandom), cnd);
      if ($urandom_range(0, 4) == 0) idle(1);
    end
    idle(6);
    check(q.size() == 0, "R3", "pending completions", 32'(q.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule